// File: doc/BRIEF.md
# Pulsed Shot Phase Sequencer

This block drives one pulsed experiment through a fixed ring of eight shot phases: idle, ramp, flat-top, burn, expansion, dump, recharge and cool-down, and then back to idle. Each phase is left only when its own guard is met. The guards come from the capacitor bank (ready and charged flags), from comparators on plasma temperature and fusion power telemetry, and from timer-expiry strobes produced outside the block. An abort request raised during any of the four active phases forces the next phase to dump, whatever the other guards say.

Every phase change is reported on an audit port. A one-cycle strobe carries the code of the phase being left and the code of the phase being entered. An external logger can record each change without polling. The block also issues scheduler commands to the bank: a level request to charge, and single-cycle pulses to fire and to dump.

All outputs come from registers. Each output shows the result of the inputs sampled at the previous rising clock edge.

Top module: `shot_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the phase output is 0 (idle) and the strobe, fire, dump and charge outputs are all low.
- R2: Phase codes: 0 idle, 1 ramp, 2 flat-top, 3 burn, 4 expansion, 5 dump, 6 recharge, 7 cool-down. Idle moves to ramp only when start and bank_ready are both high in the same cycle. Otherwise it stays in idle.
- R3: Ramp moves to flat-top when bank_charged is high. Otherwise it stays in ramp.
- R4: Flat-top moves to burn when temp_hi is high. Otherwise it stays in flat-top.
- R5: Burn moves to expansion when power_hi or burn_tmo is high. Otherwise it stays in burn.
- R6: Expansion moves to dump on expand_tmo, dump moves to recharge on dump_tmo, recharge moves to cool-down on recharge_tmo, and cool-down moves to idle on cool_tmo. Without its strobe, each of these phases holds.
- R7: When abort is high in ramp, flat-top, burn or expansion, the next phase is dump, even if that phase's own guard is also high.
- R8: Abort has no effect in idle, dump, recharge or cool-down. The phase then follows only its normal guard.
- R9: In the cycle when a new phase first shows on the phase output, xfer_vld is high, xfer_from holds the previous phase code and xfer_to holds the new one. In every other cycle xfer_vld is low.
- R10: cmd_charge is high in every cycle the phase is ramp or recharge. cmd_fire is high only in the first cycle of burn, and cmd_dump is high only in the first cycle of dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Shot start command |
| bank_ready | input | 1 | Capacitor bank is ready to begin a shot |
| bank_charged | input | 1 | Capacitor bank has reached full charge |
| temp_hi | input | 1 | Plasma temperature above threshold |
| power_hi | input | 1 | Fusion power above threshold |
| burn_tmo | input | 1 | Burn timer expired |
| expand_tmo | input | 1 | Expansion timer expired |
| dump_tmo | input | 1 | Dump timer expired |
| recharge_tmo | input | 1 | Recharge timer expired |
| cool_tmo | input | 1 | Cool-down timer expired |
| abort | input | 1 | Abort request |
| phase_o | output | 3 | Current phase code |
| xfer_vld | output | 1 | Phase-change audit strobe |
| xfer_from | output | 3 | Code of the phase being left |
| xfer_to | output | 3 | Code of the phase being entered |
| cmd_charge | output | 1 | Request to charge the bank |
| cmd_fire | output | 1 | Fire pulse |
| cmd_dump | output | 1 | Dump pulse |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. The new phase, its audit strobe with the from and to codes, and any fire, dump or charge command all appear together after that edge. The bench changes its inputs on the falling edge and advances its own reference model on the same rising edge the design uses. It then compares every output on the next falling edge, so each comparison sees exactly the first cycle in which that result is due. Held phases, abort priority and ignored aborts are all read back at that same point through the phase output and the strobe.

// File: rtl/shot_pkg.sv
package shot_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE     = 3'd0,
        PH_RAMP     = 3'd1,
        PH_FLAT     = 3'd2,
        PH_BURN     = 3'd3,
        PH_EXPAND   = 3'd4,
        PH_DUMP     = 3'd5,
        PH_RECHARGE = 3'd6,
        PH_COOL     = 3'd7
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   xfer;
        phase_e from;
        phase_e to;
        logic   charge;
        logic   fire;
        logic   dump;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        phase:  PH_IDLE,
        xfer:   1'b0,
        from:   PH_IDLE,
        to:     PH_IDLE,
        charge: 1'b0,
        fire:   1'b0,
        dump:   1'b0
    };

endpackage

// File: rtl/shot_guard.sv
module shot_guard
    import shot_pkg::*;
(
    input  phase_e cur,
    input  logic   start,
    input  logic   bank_ready,
    input  logic   bank_charged,
    input  logic   temp_hi,
    input  logic   power_hi,
    input  logic   burn_tmo,
    input  logic   expand_tmo,
    input  logic   dump_tmo,
    input  logic   recharge_tmo,
    input  logic   cool_tmo,
    input  logic   abort,
    output phase_e nxt
);

    logic active;

    always_comb begin
        active = (cur == PH_RAMP) || (cur == PH_FLAT) ||
                 (cur == PH_BURN) || (cur == PH_EXPAND);
        nxt = cur;
        if (active && abort) begin
            nxt = PH_DUMP;
        end else begin
            unique case (cur)
                PH_IDLE:     if (start && bank_ready)  nxt = PH_RAMP;
                PH_RAMP:     if (bank_charged)         nxt = PH_FLAT;
                PH_FLAT:     if (temp_hi)              nxt = PH_BURN;
                PH_BURN:     if (power_hi || burn_tmo) nxt = PH_EXPAND;
                PH_EXPAND:   if (expand_tmo)           nxt = PH_DUMP;
                PH_DUMP:     if (dump_tmo)             nxt = PH_RECHARGE;
                PH_RECHARGE: if (recharge_tmo)         nxt = PH_COOL;
                PH_COOL:     if (cool_tmo)             nxt = PH_IDLE;
                default:                               nxt = PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shot_cmd.sv
module shot_cmd
    import shot_pkg::*;
(
    input  phase_e cur,
    input  phase_e nxt,
    output logic   charge,
    output logic   fire,
    output logic   dump
);

    always_comb begin
        charge = (nxt == PH_RAMP) || (nxt == PH_RECHARGE);
        fire   = (nxt == PH_BURN) && (cur != PH_BURN);
        dump   = (nxt == PH_DUMP) && (cur != PH_DUMP);
    end

endmodule

// File: rtl/shot_sequencer.sv
module shot_sequencer
    import shot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bank_ready,
    input  logic                bank_charged,
    input  logic                temp_hi,
    input  logic                power_hi,
    input  logic                burn_tmo,
    input  logic                expand_tmo,
    input  logic                dump_tmo,
    input  logic                recharge_tmo,
    input  logic                cool_tmo,
    input  logic                abort,
    output logic [PHASE_W-1:0]  phase_o,
    output logic                xfer_vld,
    output logic [PHASE_W-1:0]  xfer_from,
    output logic [PHASE_W-1:0]  xfer_to,
    output logic                cmd_charge,
    output logic                cmd_fire,
    output logic                cmd_dump
);

    seq_regs_t regs_d, regs_q;
    phase_e    nxt_phase;
    logic      charge_d, fire_d, dump_d;

    shot_guard u_guard (
        .cur          (regs_q.phase),
        .start        (start),
        .bank_ready   (bank_ready),
        .bank_charged (bank_charged),
        .temp_hi      (temp_hi),
        .power_hi     (power_hi),
        .burn_tmo     (burn_tmo),
        .expand_tmo   (expand_tmo),
        .dump_tmo     (dump_tmo),
        .recharge_tmo (recharge_tmo),
        .cool_tmo     (cool_tmo),
        .abort        (abort),
        .nxt          (nxt_phase)
    );

    shot_cmd u_cmd (
        .cur    (regs_q.phase),
        .nxt    (nxt_phase),
        .charge (charge_d),
        .fire   (fire_d),
        .dump   (dump_d)
    );

    always_comb begin
        regs_d        = regs_q;
        regs_d.phase  = nxt_phase;
        regs_d.xfer   = (nxt_phase != regs_q.phase);
        regs_d.from   = regs_q.phase;
        regs_d.to     = nxt_phase;
        regs_d.charge = charge_d;
        regs_d.fire   = fire_d;
        regs_d.dump   = dump_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= SEQ_RESET;
        else        regs_q <= regs_d;
    end

    assign phase_o    = regs_q.phase;
    assign xfer_vld   = regs_q.xfer;
    assign xfer_from  = regs_q.from;
    assign xfer_to    = regs_q.to;
    assign cmd_charge = regs_q.charge;
    assign cmd_fire   = regs_q.fire;
    assign cmd_dump   = regs_q.dump;

    // Abort in an active phase lands in dump
    p_abort_to_dump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && phase_o >= 3'd1 && phase_o <= 3'd4) |=> (phase_o == 3'd5));

    // Idle holds without a qualified start
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd0 && !(start && bank_ready)) |=> (phase_o == 3'd0));

    // Any phase change carries an audit record
    p_change_logged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != $past(phase_o)) |-> (xfer_vld && xfer_to == phase_o
                                         && xfer_from == $past(phase_o)));

    // No record without a change
    p_no_spurious_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_vld |-> (xfer_from != xfer_to));

    // Fire only on burn entry, dump only on dump entry
    p_fire_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |-> (phase_o == 3'd3 && xfer_vld));

    p_dump_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dump |-> (phase_o == 3'd5 && xfer_vld));

    // Dump is not interrupted by abort
    p_dump_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd5 && !dump_tmo) |=> (phase_o == 3'd5));

endmodule

// File: tb/shot_sequencer_bench.sv
module shot_sequencer_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, bank_ready = 0, bank_charged = 0, temp_hi = 0, power_hi = 0;
    logic burn_tmo = 0, expand_tmo = 0, dump_tmo = 0, recharge_tmo = 0, cool_tmo = 0;
    logic abort = 0;
    logic [2:0] phase_o, xfer_from, xfer_to;
    logic xfer_vld, cmd_charge, cmd_fire, cmd_dump;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int exp_phase = 0;
    int exp_prev = 0;
    bit exp_xfer = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shot_sequencer u_shot_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .bank_ready(bank_ready),
        .bank_charged(bank_charged), .temp_hi(temp_hi), .power_hi(power_hi),
        .burn_tmo(burn_tmo), .expand_tmo(expand_tmo), .dump_tmo(dump_tmo),
        .recharge_tmo(recharge_tmo), .cool_tmo(cool_tmo), .abort(abort),
        .phase_o(phase_o), .xfer_vld(xfer_vld), .xfer_from(xfer_from),
        .xfer_to(xfer_to), .cmd_charge(cmd_charge), .cmd_fire(cmd_fire),
        .cmd_dump(cmd_dump)
    );

    // Reference: successor is always the next code in the ring; a per-phase
    // guard bit decides whether to take it; abort overrides in phases 1..4.
    function automatic int model_next(int s);
        bit go [8];
        go[0] = start && bank_ready;
        go[1] = bank_charged;
        go[2] = temp_hi;
        go[3] = power_hi || burn_tmo;
        go[4] = expand_tmo;
        go[5] = dump_tmo;
        go[6] = recharge_tmo;
        go[7] = cool_tmo;
        if (abort && s >= 1 && s <= 4) return 5;
        return go[s] ? (s + 1) % 8 : s;
    endfunction

    task automatic compare(string tag);
        logic [12:0] got, want;
        bit w_charge, w_fire, w_dump;
        w_charge = (exp_phase == 1) || (exp_phase == 6);
        w_fire   = exp_xfer && exp_phase == 3;
        w_dump   = exp_xfer && exp_phase == 5;
        got  = {phase_o, xfer_vld, xfer_vld ? xfer_from : 3'd0,
                xfer_vld ? xfer_to : 3'd0, cmd_charge, cmd_fire, cmd_dump};
        want = {exp_phase[2:0], exp_xfer, exp_xfer ? exp_prev[2:0] : 3'd0,
                exp_xfer ? exp_phase[2:0] : 3'd0, w_charge, w_fire, w_dump};
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: {phase,vld,from,to,chg,fire,dump} got %b expected %b",
                     tag, got, want);
        end
    endtask

    task automatic clear_inputs();
        start = 0; bank_ready = 0; bank_charged = 0; temp_hi = 0; power_hi = 0;
        burn_tmo = 0; expand_tmo = 0; dump_tmo = 0; recharge_tmo = 0;
        cool_tmo = 0; abort = 0;
    endtask

    // Inputs are set before the call; one edge later the result is compared.
    task automatic cycle(string tag);
        int nx;
        @(posedge clk);
        nx = model_next(exp_phase);
        exp_xfer = (nx != exp_phase);
        exp_prev = exp_phase;
        exp_phase = nx;
        @(negedge clk);
        compare(tag);
        clear_inputs();
    endtask

    task automatic go_to_burn();
        start = 1; bank_ready = 1; cycle("R2 start");
        bank_charged = 1; cycle("R3 charged");
        temp_hi = 1; cycle("R4 temp");
    endtask

    task automatic finish_cycle_from_dump();
        dump_tmo = 1; cycle("R6 dump done");
        recharge_tmo = 1; cycle("R6 recharge done");
        cool_tmo = 1; cycle("R6 cool done");
    endtask

    initial begin
        @(negedge clk);
        compare("R1 in reset");
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1 after reset");

        start = 1; cycle("R2 start without ready");
        bank_ready = 1; cycle("R2 ready without start");
        abort = 1; cycle("R8 abort in idle");
        start = 1; bank_ready = 1; cycle("R2 start");
        repeat (3) begin temp_hi = 1; cycle("R3 ramp holds"); end
        bank_charged = 1; cycle("R3 charged");
        power_hi = 1; cycle("R4 flat holds");
        temp_hi = 1; cycle("R4 temp");
        expand_tmo = 1; cycle("R5 burn holds");
        burn_tmo = 1; cycle("R5 burn timer");
        dump_tmo = 1; cycle("R6 expansion holds");
        expand_tmo = 1; cycle("R6 expansion done");
        abort = 1; cycle("R8 abort in dump");
        finish_cycle_from_dump();

        go_to_burn();
        power_hi = 1; cycle("R5 power exit");
        expand_tmo = 1; cycle("R6 expansion done");
        dump_tmo = 1; cycle("R6 dump done");
        abort = 1; cycle("R8 abort in recharge");
        recharge_tmo = 1; cycle("R6 recharge done");
        abort = 1; cycle("R8 abort in cool");
        cool_tmo = 1; cycle("R6 cool done");

        start = 1; bank_ready = 1; cycle("R2 start");
        abort = 1; bank_charged = 1; cycle("R7 abort in ramp");
        finish_cycle_from_dump();

        start = 1; bank_ready = 1; cycle("R2 start");
        bank_charged = 1; cycle("R3 charged");
        abort = 1; temp_hi = 1; cycle("R7 abort in flat");
        finish_cycle_from_dump();

        go_to_burn();
        abort = 1; power_hi = 1; cycle("R7 abort in burn");
        finish_cycle_from_dump();

        go_to_burn();
        burn_tmo = 1; cycle("R5 burn timer");
        abort = 1; cycle("R7 abort in expansion");
        repeat (2) cycle("R9 dump holds, no strobe");
        finish_cycle_from_dump();

        // Back-to-back transitions produce back-to-back strobes
        start = 1; bank_ready = 1; cycle("R9 strobe 1");
        bank_charged = 1; cycle("R9 strobe 2");
        temp_hi = 1; cycle("R10 fire pulse");
        cycle("R10 fire drops");
        power_hi = 1; cycle("R9 strobe 4");
        expand_tmo = 1; cycle("R10 dump pulse");
        cycle("R10 dump drops");

        rst_n = 0;
        @(negedge clk);
        exp_phase = 0; exp_xfer = 0; exp_prev = 0;
        compare("R1 mid-run reset");
        rst_n = 1;
        @(negedge clk);
        compare("R1 after second reset");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule